// File: doc/BRIEF.md
# Retrying Program-and-Verify Sequencer for a Byte-Wide EPROM

This block sits on the host side of an EPROM programming fixture. It writes a chosen address range into the target with a bounded pulse-and-check loop. Software or a higher-level controller gives it a first address, a last address, a unit mode (single byte or a page of `PAGE_BYTES` bytes) and a one-cycle start pulse. The sequencer asks a byte source for the data at each address. It drives the target's enable, output and program strobe pins, its address and data buses, and a supply select that picks the raised programming levels or the normal levels. When it stops it shows either a sticky done flag or a sticky defective flag.

Each unit (one byte, or one page) is programmed with its own retry count. In page mode the bytes of the page are first latched into the target one after another, and then a single program pulse writes them. In byte mode every pulse writes one byte directly. After each pulse the unit is read back while the supply is still raised. A mismatch triggers another pulse, up to `MAX_TRIES` pulses per unit. Once the range has been programmed, the supply drops to normal and every byte is read back one more time. Only this last pass decides whether the result is done or defective. The program pulse lasts `PULSE_CYC` clock cycles. Every strobe edge has a setup cycle before it and a hold cycle after it.

States: `S_IDLE` (standby), `S_REJECT` (bad range, one cycle), `S_RAISE` (supply up), `S_LAT_SET`/`S_LAT_STB`/`S_LAT_HLD` (page byte latch), `S_PUL_SET`/`S_PUL_LOW`/`S_PUL_HLD` (program pulse), `S_VFY_SET`/`S_VFY_RD`/`S_VFY_HLD` (read back a unit), `S_VFY_EVAL` (judge the unit), `S_LOWER` (supply down), `S_FIN_SET`/`S_FIN_RD`/`S_FIN_HLD` (final pass).

Transitions:
- `S_IDLE` goes to `S_RAISE` when start arrives with a valid range, or to `S_REJECT` when the range is invalid.
- `S_RAISE` goes to the latch states in page mode and to `S_PUL_SET` in byte mode.
- After the last byte of the page, the latch states lead to `S_PUL_SET`.
- The pulse states lead to the verify states, and those lead to `S_VFY_EVAL`.
- From `S_VFY_EVAL` the sequencer either pulses again, moves on to the next unit, goes to `S_LOWER`, or returns to `S_IDLE` as defective.
- `S_LOWER` leads into the final-pass states. These step through the range and end in `S_IDLE`.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset and whenever the block is idle, the following hold: busy is 0, done, defective and align_err are 0 until a run sets them, all three pin levels (enable, output, program) are 1, hi_volt is 0 and tgt_wdrive is 0.
- R2: In byte mode, each address is programmed by a pulse in which enable=0, output=1 and program=0, while the source data for that address is driven. The address is then read with enable=0, output=0 and the bus released. A range whose bytes all program on the first pulse ends with done=1 after exactly one pulse per byte.
- R3: hi_volt is 1 (raised supply) throughout every program pulse and every read-back after a pulse. It is 0 (normal supply) throughout the final pass and when done or defective is raised.
- R4: The program pin stays at level 0 for exactly `PULSE_CYC` consecutive cycles on every pulse.
- R5: The pulse count of a unit starts at zero. A unit that first reads back correctly after its Nth pulse, with N no greater than `MAX_TRIES` (10), takes exactly N pulses and the run goes on.
- R6: A unit that still reads back wrong after its `MAX_TRIES`th pulse sets defective=1. No further pulse is applied and no later address is touched.
- R7: In page mode, each of the `PAGE_BYTES` (4) bytes of a page is latched with enable=1, program=1 and a one-cycle output=0 strobe, at consecutive addresses. Then one pulse with enable=1, output=1, program=0 writes the page. Verification reads all bytes of the page, and the page passes only if every byte matches.
- R8: After every unit has passed, each byte from first to last address is read once more at normal supply. Any mismatch sets defective=1, even when every unit passed its own check. A clean pass sets done=1.
- R9: A start is rejected with align_err=1 after one busy cycle, and with no pulse, when last address < first address, or in page mode when the first address has low bits (log2 `PAGE_BYTES`) not all 0 or the last address has those bits not all 1.
- R10: done, defective and align_err stay set until the next accepted start, and that start clears all three by the following cycle. At most one of them is set at any time.
- R11: A start that arrives while busy=1 has no effect on the running job, on its pulse count or on its outcome.
- R12: A range of exactly one unit (one byte, or one page) is programmed and finishes correctly.
- R13: The retry count is cleared for every unit, so each unit of a range may take up to `MAX_TRIES` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start request |
| first_addr | input | AW | First address of the range |
| last_addr | input | AW | Last address of the range |
| page_mode | input | 1 | 1 = page units, 0 = byte units |
| src_addr | output | AW | Address whose data is requested |
| src_data | input | 8 | Data for src_addr, same cycle |
| tgt_addr | output | AW | Target address bus |
| tgt_wdata | output | 8 | Target data bus, write direction |
| tgt_wdrive | output | 1 | 1 = host drives the target data bus |
| tgt_rdata | input | 8 | Target data bus, read direction |
| tgt_en_lvl | output | 1 | Level of the target enable pin |
| tgt_out_lvl | output | 1 | Level of the target output pin |
| tgt_prg_lvl | output | 1 | Level of the target program pin |
| hi_volt | output | 1 | 1 = raised programming supplies, 0 = normal |
| busy | output | 1 | Job in progress |
| done | output | 1 | Sticky: range programmed and verified |
| defective | output | 1 | Sticky: target failed |
| align_err | output | 1 | Sticky: range rejected |

## Verification
Suppose the unit offset or the retry count is wrong inside the block. At the ports, the first sign is the number of program-pin falling edges per job, or a final flag that differs from the one the target model's reads call for. Either shows at the end of the job in which the state went wrong. A fault in the strobe decode is different: it shows within the very pulse or latch concerned, either as a pulse width that is not `PULSE_CYC`, as a pulse taken at normal supply, or as target contents that do not match the source after a done. The bench target model needs a chosen number of pulses per address and can give a wrong read only at normal supply. With it, retry exhaustion, retry reset between units, and a failure seen only in the final pass can each be provoked and scored against predicted pulse counts.

// File: rtl/eps_pkg.sv
package eps_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_REJECT,
        S_RAISE,
        S_LAT_SET,
        S_LAT_STB,
        S_LAT_HLD,
        S_PUL_SET,
        S_PUL_LOW,
        S_PUL_HLD,
        S_VFY_SET,
        S_VFY_RD,
        S_VFY_HLD,
        S_VFY_EVAL,
        S_LOWER,
        S_FIN_SET,
        S_FIN_RD,
        S_FIN_HLD
    } eps_state_t;

endpackage

// File: rtl/eps_range_chk.sv
// Decides whether a requested range can be programmed in the chosen unit mode.
module eps_range_chk #(
    parameter int AW = 16,
    parameter int OW = 2
) (
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    input  logic          page_mode,
    output logic          range_ok
);
    logic order_ok;
    logic page_ok;

    always_comb begin
        order_ok = (last_addr >= first_addr);
        page_ok  = (first_addr[OW-1:0] == '0) && (&last_addr[OW-1:0]);
        range_ok = order_ok && (!page_mode || page_ok);
    end
endmodule

// File: rtl/eps_pulse_timer.sv
// Down counter that sets the width of the program pulse.
module eps_pulse_timer #(
    parameter int PULSE_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expired
);
    localparam int TW = $clog2(PULSE_CYC + 1);
    localparam logic [TW-1:0] RELOAD = TW'(PULSE_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/eps_retry_ctr.sv
// Counts the failed pulses of the current unit.
module eps_retry_ctr #(
    parameter int MAX_TRIES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last_try
);
    localparam int CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] tries;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries <= '0;
        end else if (clear) begin
            tries <= '0;
        end else if (bump) begin
            tries <= tries + CW'(1);
        end
    end

    // High while the pulse just checked is the final one permitted for this unit.
    assign last_try = (tries == CW'(MAX_TRIES - 1));
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eps_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PULSE_CYC  = 1250,
    parameter int MAX_TRIES  = 10,
    parameter int PAGE_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    input  logic          page_mode,
    output logic [AW-1:0] src_addr,
    input  logic [7:0]    src_data,
    output logic [AW-1:0] tgt_addr,
    output logic [7:0]    tgt_wdata,
    output logic          tgt_wdrive,
    input  logic [7:0]    tgt_rdata,
    output logic          tgt_en_lvl,
    output logic          tgt_out_lvl,
    output logic          tgt_prg_lvl,
    output logic          hi_volt,
    output logic          busy,
    output logic          done,
    output logic          defective,
    output logic          align_err
);
    localparam int OW = $clog2(PAGE_BYTES);
    localparam logic [OW-1:0] OFF_TOP  = OW'(PAGE_BYTES - 1);
    localparam logic [AW-1:0] PAGE_SPAN = AW'(PAGE_BYTES - 1);

    eps_state_t    state, nxt;
    logic [AW-1:0] unit_base;
    logic [OW-1:0] off;
    logic [AW-1:0] first_q, last_q;
    logic          page_q;
    logic          miss;
    logic          done_q, def_q, err_q;

    logic [AW-1:0] cur_addr;
    logic [AW-1:0] unit_end;
    logic          off_last;
    logic          rd_bad;
    logic          range_ok;
    logic          pulse_over;
    logic          last_try;
    logic          retry_clear, retry_bump;

    assign cur_addr = unit_base + AW'(off);
    assign unit_end = page_q ? (unit_base + PAGE_SPAN) : unit_base;
    assign off_last = page_q ? (off == OFF_TOP) : 1'b1;
    assign rd_bad   = (tgt_rdata != src_data);

    eps_range_chk #(.AW(AW), .OW(OW)) u_range (
        .first_addr (first_addr),
        .last_addr  (last_addr),
        .page_mode  (page_mode),
        .range_ok   (range_ok)
    );

    eps_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == S_PUL_SET),
        .tick    (state == S_PUL_LOW),
        .expired (pulse_over)
    );

    assign retry_clear = ((state == S_IDLE) && start) || ((state == S_VFY_EVAL) && !miss);
    assign retry_bump  = (state == S_VFY_EVAL) && miss && !last_try;

    eps_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (retry_clear),
        .bump     (retry_bump),
        .last_try (last_try)
    );

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = range_ok ? S_RAISE : S_REJECT;
            S_REJECT:   nxt = S_IDLE;
            S_RAISE:    nxt = page_q ? S_LAT_SET : S_PUL_SET;
            S_LAT_SET:  nxt = S_LAT_STB;
            S_LAT_STB:  nxt = S_LAT_HLD;
            S_LAT_HLD:  nxt = off_last ? S_PUL_SET : S_LAT_SET;
            S_PUL_SET:  nxt = S_PUL_LOW;
            S_PUL_LOW:  if (pulse_over) nxt = S_PUL_HLD;
            S_PUL_HLD:  nxt = S_VFY_SET;
            S_VFY_SET:  nxt = S_VFY_RD;
            S_VFY_RD:   nxt = S_VFY_HLD;
            S_VFY_HLD:  nxt = off_last ? S_VFY_EVAL : S_VFY_SET;
            S_VFY_EVAL: begin
                if (miss)                   nxt = last_try ? S_IDLE : S_PUL_SET;
                else if (unit_end == last_q) nxt = S_LOWER;
                else                         nxt = page_q ? S_LAT_SET : S_PUL_SET;
            end
            S_LOWER:    nxt = S_FIN_SET;
            S_FIN_SET:  nxt = S_FIN_RD;
            S_FIN_RD:   nxt = S_FIN_HLD;
            S_FIN_HLD:  nxt = (miss || (unit_base == last_q)) ? S_IDLE : S_FIN_SET;
            default:    nxt = S_IDLE;
        endcase
    end

    // State register and the working registers it steers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            unit_base <= '0;
            off       <= '0;
            first_q   <= '0;
            last_q    <= '0;
            page_q    <= 1'b0;
            miss      <= 1'b0;
            done_q    <= 1'b0;
            def_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: if (start) begin
                    done_q    <= 1'b0;
                    def_q     <= 1'b0;
                    err_q     <= 1'b0;
                    page_q    <= page_mode;
                    first_q   <= first_addr;
                    last_q    <= last_addr;
                    unit_base <= first_addr;
                    off       <= '0;
                end
                S_REJECT:  err_q <= 1'b1;
                S_LAT_HLD: off <= off_last ? '0 : off + OW'(1);
                S_PUL_HLD: begin
                    off  <= '0;
                    miss <= 1'b0;
                end
                S_VFY_RD:  if (rd_bad) miss <= 1'b1;
                S_VFY_HLD: if (!off_last) off <= off + OW'(1);
                S_VFY_EVAL: begin
                    if (miss) begin
                        if (last_try) def_q <= 1'b1;
                    end else if (unit_end != last_q) begin
                        unit_base <= unit_end + AW'(1);
                        off       <= '0;
                    end
                end
                S_LOWER: begin
                    unit_base <= first_q;
                    off       <= '0;
                    miss      <= 1'b0;
                end
                S_FIN_RD:  if (rd_bad) miss <= 1'b1;
                S_FIN_HLD: begin
                    if (miss)                     def_q  <= 1'b1;
                    else if (unit_base == last_q) done_q <= 1'b1;
                    else                          unit_base <= unit_base + AW'(1);
                end
                default: ;
            endcase
        end
    end

    // Pin levels and supply select decoded from the state
    always_comb begin
        tgt_en_lvl  = 1'b1;
        tgt_out_lvl = 1'b1;
        tgt_prg_lvl = 1'b1;
        tgt_wdrive  = 1'b0;
        hi_volt     = 1'b0;
        unique case (state)
            S_IDLE, S_REJECT, S_LOWER: ;
            S_RAISE: hi_volt = 1'b1;
            S_LAT_SET, S_LAT_HLD: begin
                hi_volt    = 1'b1;
                tgt_wdrive = 1'b1;
            end
            S_LAT_STB: begin
                hi_volt     = 1'b1;
                tgt_wdrive  = 1'b1;
                tgt_out_lvl = 1'b0;
            end
            S_PUL_SET, S_PUL_HLD: begin
                hi_volt    = 1'b1;
                tgt_en_lvl = page_q;
                tgt_wdrive = !page_q;
            end
            S_PUL_LOW: begin
                hi_volt     = 1'b1;
                tgt_en_lvl  = page_q;
                tgt_wdrive  = !page_q;
                tgt_prg_lvl = 1'b0;
            end
            S_VFY_SET, S_VFY_HLD: begin
                hi_volt    = 1'b1;
                tgt_en_lvl = 1'b0;
            end
            S_VFY_RD: begin
                hi_volt     = 1'b1;
                tgt_en_lvl  = 1'b0;
                tgt_out_lvl = 1'b0;
            end
            S_VFY_EVAL: hi_volt = 1'b1;
            S_FIN_SET, S_FIN_HLD: tgt_en_lvl = 1'b0;
            S_FIN_RD: begin
                tgt_en_lvl  = 1'b0;
                tgt_out_lvl = 1'b0;
            end
            default: ;
        endcase
    end

    assign src_addr  = cur_addr;
    assign tgt_addr  = cur_addr;
    assign tgt_wdata = src_data;
    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign defective = def_q;
    assign align_err = err_q;

endmodule

// File: rtl/eps_checker.sv
module eps_checker #(
    parameter int PULSE_CYC = 1250
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic defective,
    input logic align_err,
    input logic en_lvl,
    input logic out_lvl,
    input logic prg_lvl,
    input logic wdrive,
    input logic hv
);
    localparam logic [31:0] PW = 32'(PULSE_CYC);

    logic [31:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_cnt <= '0;
        else if (!prg_lvl) low_cnt <= low_cnt + 32'd1;
        else               low_cnt <= '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (en_lvl && out_lvl && prg_lvl && !hv && !wdrive));

    assert_no_bus_fight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_lvl && !out_lvl) |-> !wdrive);

    assert_pulse_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !prg_lvl |-> hv);

    assert_flag_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) || $rose(defective)) |-> !hv);

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prg_lvl) |-> (low_cnt == PW));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, defective, align_err}));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_defective_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (defective && !start) |=> defective);

endmodule

bind eprom_prog_seq eps_checker #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .defective (defective),
    .align_err (align_err),
    .en_lvl    (tgt_en_lvl),
    .out_lvl   (tgt_out_lvl),
    .prg_lvl   (tgt_prg_lvl),
    .wdrive    (tgt_wdrive),
    .hv        (hi_volt)
);

// File: tb/eprom_prog_seq_tb.sv
`timescale 1ns/1ps
module eprom_prog_seq_tb;
    localparam int AW = 10;
    localparam int PW = 6;
    localparam int MT = 10;
    localparam int PB = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, start, page_mode;
    logic [AW-1:0] first_addr, last_addr, src_addr, tgt_addr;
    logic [7:0]    src_data, tgt_wdata, tgt_rdata;
    logic          tgt_wdrive, tgt_en_lvl, tgt_out_lvl, tgt_prg_lvl, hi_volt;
    logic          busy, done, defective, align_err;

    eprom_prog_seq #(.AW(AW), .PULSE_CYC(PW), .MAX_TRIES(MT), .PAGE_BYTES(PB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
        .last_addr(last_addr), .page_mode(page_mode), .src_addr(src_addr),
        .src_data(src_data), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_wdrive(tgt_wdrive), .tgt_rdata(tgt_rdata), .tgt_en_lvl(tgt_en_lvl),
        .tgt_out_lvl(tgt_out_lvl), .tgt_prg_lvl(tgt_prg_lvl), .hi_volt(hi_volt),
        .busy(busy), .done(done), .defective(defective), .align_err(align_err)
    );

    // Source pattern: bit 0 always 0, so never the erased value
    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return {a[6:0], 1'b0} ^ 8'h5A;
    endfunction
    assign src_data = pat(src_addr);

    // ---------------- target model ----------------
    logic [7:0]    mem [0:DEPTH-1];
    int            hits [0:DEPTH-1];
    int            need [0:DEPTH-1];
    logic [7:0]    latch [0:PB-1];
    logic          corrupt_on;
    logic [AW-1:0] corrupt_a;
    int            clr_tok, clr_seen;
    int            plo, pulses, width_bad, supply_bad;
    logic          pce;
    logic [AW-1:0] paddr;
    logic [7:0]    pdata;

    assign tgt_rdata = (!tgt_en_lvl && !tgt_out_lvl)
        ? (mem[tgt_addr] ^ ((corrupt_on && tgt_addr == corrupt_a && !hi_volt) ? 8'h01 : 8'h00))
        : 8'hFF;

    task automatic burn(input logic [AW-1:0] a, input logic [7:0] d);
        hits[a] = hits[a] + 1;
        if (hits[a] >= need[a]) mem[a] = d;
    endtask

    initial begin
        clr_seen = -1; plo = 0; pulses = 0; width_bad = 0; supply_bad = 0;
        pce = 1'b0; paddr = '0; pdata = '0;
    end

    always @(negedge clk) begin
        if (clr_tok != clr_seen) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]  = 8'hFF;
                hits[i] = 0;
            end
            clr_seen = clr_tok;
        end
        if (tgt_en_lvl && !tgt_out_lvl && tgt_prg_lvl && tgt_wdrive)
            latch[tgt_addr[1:0]] = tgt_wdata;
        if (!tgt_prg_lvl) begin
            if (plo == 0) begin
                pulses = pulses + 1;
                if (!hi_volt) supply_bad = supply_bad + 1;
                pce   = tgt_en_lvl;
                paddr = tgt_addr;
                pdata = tgt_wdata;
            end
            plo = plo + 1;
        end else if (plo > 0) begin
            if (plo != PW) width_bad = width_bad + 1;
            if (pce) begin
                for (int j = 0; j < PB; j++)
                    burn({paddr[AW-1:2], 2'(j)}, latch[j]);
            end else begin
                burn(paddr, pdata);
            end
            plo = 0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic  d;
        logic  f;
        logic  e;
        int    np;
        int    base;
        string tag;
    } exp_t;
    exp_t q[$];

    int drv_chk = 0, drv_err = 0, mon_chk = 0, mon_err = 0;
    logic finished = 1'b0;

    task automatic dchk(input bit ok, input string tag, input string what, input int act, input int exp);
        drv_chk++;
        if (!ok) begin
            drv_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expectation each time a finish flag rises
    logic fin_q = 1'b0;
    exp_t mit;
    always @(negedge clk) begin
        logic fin;
        fin = done | defective | align_err;
        if (rst_n && fin && !fin_q) begin
            if (q.size() == 0) begin
                mon_chk++; mon_err++;
                $display("FAIL R10 unexpected finish: actual=1 expected=0");
            end else begin
                mit = q.pop_front();
                mon_chk++;
                if (done != mit.d) begin
                    mon_err++;
                    $display("FAIL %s done: actual=%0d expected=%0d", mit.tag, done, mit.d);
                end
                mon_chk++;
                if (defective != mit.f) begin
                    mon_err++;
                    $display("FAIL %s defective: actual=%0d expected=%0d", mit.tag, defective, mit.f);
                end
                mon_chk++;
                if (align_err != mit.e) begin
                    mon_err++;
                    $display("FAIL %s align_err: actual=%0d expected=%0d", mit.tag, align_err, mit.e);
                end
                mon_chk++;
                if ((pulses - mit.base) != mit.np) begin
                    mon_err++;
                    $display("FAIL %s pulses: actual=%0d expected=%0d", mit.tag, pulses - mit.base, mit.np);
                end
            end
        end
        fin_q = fin;
    end

    // Driver: push an expectation, launch the job, wait for the monitor
    task automatic run_job(input logic [AW-1:0] f, input logic [AW-1:0] l, input logic pm,
                           input logic ed, input logic ef, input logic ee, input int np,
                           input string tag, input int poke_at);
        exp_t it;
        int   n;
        clr_tok++;
        @(negedge clk);
        @(negedge clk);
        it.d = ed; it.f = ef; it.e = ee; it.np = np; it.base = pulses; it.tag = tag;
        q.push_back(it);
        first_addr = f; last_addr = l; page_mode = pm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dchk(busy && !done && !defective && !align_err, "R10", {tag, " flags cleared by start"},
             {busy, done, defective, align_err}, 4'b1000);
        n = 0;
        while (q.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke_at > 0 && n == poke_at) begin
                first_addr = f + 1; last_addr = f; page_mode = 1'b1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        dchk(q.size() == 0, tag, "job finished in time", q.size(), 0);
    endtask

    task automatic chk_mem(input logic [AW-1:0] f, input logic [AW-1:0] l, input string tag);
        int bad;
        bad = 0;
        for (int a = int'(f); a <= int'(l); a++)
            if (mem[a] != pat(AW'(a))) bad++;
        dchk(bad == 0, tag, "target contents match source", bad, 0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", drv_err + mon_err + 1, drv_chk + mon_chk + 1);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; page_mode = 1'b0; first_addr = '0; last_addr = '0;
        clr_tok = 0; corrupt_on = 1'b0; corrupt_a = '0;
        for (int i = 0; i < DEPTH; i++) need[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        dchk(!busy && !done && !defective && !align_err, "R1", "status after reset",
             {busy, done, defective, align_err}, 0);
        dchk(tgt_en_lvl && tgt_out_lvl && tgt_prg_lvl && !hi_volt && !tgt_wdrive, "R1",
             "pins after reset", {tgt_en_lvl, tgt_out_lvl, tgt_prg_lvl, hi_volt, tgt_wdrive}, 5'b11100);

        // R2 byte mode, one pulse each
        run_job(10'h010, 10'h014, 1'b0, 1, 0, 0, 5, "R2", 0);
        chk_mem(10'h010, 10'h014, "R2");
        dchk(!hi_volt && !busy, "R3", "normal supply after done", hi_volt, 0);
        repeat (30) @(negedge clk);
        dchk(done && !defective, "R10", "done sticky while idle", done, 1);

        // R5 unit passes on its tenth pulse
        need[10'h032] = 10;
        run_job(10'h030, 10'h033, 1'b0, 1, 0, 0, 13, "R5", 0);
        chk_mem(10'h030, 10'h033, "R5");
        need[10'h032] = 1;

        // R6 unit never passes: ten pulses then stop
        need[10'h042] = 11;
        run_job(10'h040, 10'h044, 1'b0, 0, 1, 0, 12, "R6", 0);
        dchk(mem[10'h043] == 8'hFF && mem[10'h044] == 8'hFF, "R6", "later bytes untouched",
             int'(mem[10'h043]), 255);
        repeat (20) @(negedge clk);
        dchk(defective && !done, "R10", "defective sticky while idle", defective, 1);
        need[10'h042] = 1;

        // R7 page mode, second page needs three pulses
        need[10'h025] = 3;
        run_job(10'h020, 10'h027, 1'b1, 1, 0, 0, 4, "R7", 0);
        chk_mem(10'h020, 10'h027, "R7");
        need[10'h025] = 1;

        // R6 in page mode: one bad byte fails the whole page
        need[10'h089] = 11;
        run_job(10'h088, 10'h08B, 1'b1, 0, 1, 0, 10, "R6 page", 0);
        need[10'h089] = 1;

        // R9 rejected ranges
        run_job(10'h021, 10'h024, 1'b1, 0, 0, 1, 0, "R9 misaligned first", 0);
        run_job(10'h020, 10'h026, 1'b1, 0, 0, 1, 0, "R9 misaligned last", 0);
        run_job(10'h015, 10'h010, 1'b0, 0, 0, 1, 0, "R9 reversed", 0);
        repeat (10) @(negedge clk);
        dchk(align_err && !busy, "R10", "align_err sticky while idle", align_err, 1);

        // R8 failure visible only at normal supply
        corrupt_on = 1'b1; corrupt_a = 10'h052;
        run_job(10'h050, 10'h053, 1'b0, 0, 1, 0, 4, "R8", 0);
        corrupt_on = 1'b0;

        // R12 single-unit ranges
        run_job(10'h060, 10'h060, 1'b0, 1, 0, 0, 1, "R12 byte", 0);
        chk_mem(10'h060, 10'h060, "R12");
        run_job(10'h064, 10'h067, 1'b1, 1, 0, 0, 1, "R12 page", 0);
        chk_mem(10'h064, 10'h067, "R12");

        // R13 retry count restarts for each unit
        need[10'h070] = 6; need[10'h071] = 6;
        run_job(10'h070, 10'h071, 1'b0, 1, 0, 0, 12, "R13", 0);
        chk_mem(10'h070, 10'h071, "R13");
        need[10'h070] = 1; need[10'h071] = 1;

        // R11 start while busy is ignored
        run_job(10'h080, 10'h083, 1'b0, 1, 0, 0, 4, "R11", 7);
        chk_mem(10'h080, 10'h083, "R11");

        // R3 / R4 over every pulse of the run
        dchk(supply_bad == 0, "R3", "pulses taken at normal supply", supply_bad, 0);
        dchk(width_bad == 0, "R4", "pulses of wrong width", width_bad, 0);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", drv_err + mon_err, drv_chk + mon_chk);
        $finish;
    end
endmodule